// File: doc/BRIEF.md
# Pair-Packing Synchronous FIFO over Single-Port Storage

This block is a synchronous word FIFO that accepts one write and one read in the same clock cycle, although its storage is a single-port memory that performs only one access per cycle. The memory is twice as wide as a FIFO word and half as deep as the logical capacity. Two consecutive written words are packed into one memory word, and one memory read yields two consecutive words for the reader. Each memory access therefore serves two FIFO operations, which leaves enough port bandwidth for a full-rate write stream and a full-rate read stream together.

A one-word holding register collects the first word of a pair. A pair register holds a completed pair until the memory port is free. A small output word buffer unpacks fetched pairs and presents the head word. When the memory holds nothing, words skip the memory and go straight from the staging registers to the output buffer. This lets a lone word, such as the last word of an odd-length burst, reach the reader without waiting for a partner. When both a pair-write and a pair-read want the port in the same cycle, they take turns.

Occupancy is counted in words. The FIFO reports full at exactly `DEPTH` words and empty at zero words. The memory is an inferred array with a one-cycle registered read, and its size follows from the `DEPTH` parameter.

Top module: `pairpack_fifo`

## Requirements
- R1: Words leave in exactly the order they were accepted, with no loss and no duplication, under any mix of writes and reads, including a write and a read in the same cycle.
- R2: While `rst_ni` is low and right after it rises, `rd_valid_o` is 0, `empty_o` is 1 and `wr_full_o` is 0.
- R3: `wr_full_o` is 1 whenever `DEPTH` words are held. A write offered while `wr_full_o` is 1 is dropped: after draining, exactly `DEPTH` words come out.
- R4: When a packed pair and a pair fetch both want the memory port, the two take turns, so a packed pair never waits more than one cycle. As a result, a continuous stream of one write and one read per cycle is never refused on the write side.
- R5: A word written into an empty FIFO, with no partner word following, is presented with `rd_valid_o` = 1 from the second rising edge after the edge that accepted it.
- R6: `empty_o` is 1 exactly when zero words are held, and `rd_valid_o` is never 1 while `empty_o` is 1.
- R7: Once 12 or more words are held, a stream of one write and one read on every cycle keeps `rd_valid_o` at 1 on every cycle.
- R8: `wr_full_o` is 1 only when `DEPTH` words are held. The staging registers never refuse a write below that level.
- R9: While `rd_valid_o` is 1 and `rd_ready_i` is 0, `rd_valid_o` stays 1 and `rd_data_o` stays unchanged on the next cycle.
- R10: Every word of an odd-length burst, including the unpaired last word, reaches the reader without any further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write request; taken when `wr_full_o` is 0 |
| wr_data_i | input | DATA_W | Word to write |
| wr_full_o | output | 1 | FIFO holds DEPTH words; writes are refused |
| rd_ready_i | input | 1 | Reader takes the head word when `rd_valid_o` is 1 |
| rd_valid_o | output | 1 | Head word is present on `rd_data_o` |
| rd_data_o | output | DATA_W | Head word |
| empty_o | output | 1 | FIFO holds no words |

## Verification
A wrong staging or pointer state shows up at the ports as a reordered, repeated or missing word. The bench catches it on the very read that returns it, because every returned word is compared against a word-level queue. A mismatch in the occupancy count, or a pair register left waiting for the port, changes `wr_full_o` or `empty_o` on the same cycle, and the bench compares both on every clock. A stalled fetch or a lost lone word instead drops `rd_valid_o` during a sustained stream, or leaves it low two cycles after a write into an empty FIFO. Both conditions are sampled at those exact cycles.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    GNT_NONE = 2'd0,
    GNT_WR   = 2'd1,
    GNT_RD   = 2'd2
  } grant_e;
endpackage

// File: rtl/pp_sp_ram.sv
module pp_sp_ram #(
  parameter int DW    = 64,
  parameter int WORDS = 16,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [WORDS];

  // one access per cycle: write or registered read
  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/pp_in_stage.sv
module pp_in_stage #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          take_single_i,
  input  logic          take_pair_i,
  output logic          single_vld_o,
  output logic [DW-1:0] single_o,
  output logic          pair_vld_o,
  output logic [2*DW-1:0] pair_o
);
  logic form_pair;

  // a second word joins the held one unless the held one leaves now
  assign form_pair = wr_i && single_vld_o && !take_single_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      single_vld_o <= 1'b0;
      pair_vld_o   <= 1'b0;
    end else begin
      if (wr_i && !form_pair)             single_vld_o <= 1'b1;
      else if (form_pair || take_single_i) single_vld_o <= 1'b0;

      if (form_pair)        pair_vld_o <= 1'b1;
      else if (take_pair_i) pair_vld_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i && !form_pair) single_o <= wdata_i;
    if (form_pair)          pair_o   <= {wdata_i, single_o};  // older word in low half
  end
endmodule

// File: rtl/pp_out_stage.sv
module pp_out_stage #(
  parameter int DW    = 32,
  parameter int SLOTS = 6,
  parameter int CW    = $clog2(SLOTS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push1_i,
  input  logic            push2_i,
  input  logic [2*DW-1:0] din_i,
  input  logic            pop_i,
  output logic [CW-1:0]   cnt_o,
  output logic [DW-1:0]   head_o
);
  logic [DW-1:0] slot_q [SLOTS];
  logic [DW-1:0] slot_d [SLOTS];
  logic [CW-1:0] cnt_q;
  int            base;
  int            cnt_d;

  always_comb begin
    slot_d = slot_q;
    base   = int'(cnt_q);
    if (pop_i) begin
      for (int i = 0; i < SLOTS - 1; i++) slot_d[i] = slot_q[i+1];
      base = base - 1;
    end
    for (int i = 0; i < SLOTS; i++) begin
      if ((push1_i || push2_i) && i == base) slot_d[i] = din_i[DW-1:0];
      if (push2_i && i == base + 1)          slot_d[i] = din_i[2*DW-1:DW];
    end
    cnt_d = base + (push2_i ? 2 : (push1_i ? 1 : 0));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= CW'(cnt_d);
  end

  always_ff @(posedge clk_i) begin
    slot_q <= slot_d;
  end

  assign cnt_o  = cnt_q;
  assign head_o = slot_q[0];
endmodule

// File: rtl/pairpack_fifo.sv
module pairpack_fifo #(
  parameter int DATA_W    = 32,
  parameter int DEPTH     = 32,
  parameter int OUT_SLOTS = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_full_o,
  input  logic              rd_ready_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o
);
  import pp_pkg::*;

  localparam int PAIR_W    = 2 * DATA_W;
  localparam int MEM_WORDS = DEPTH / 2;
  localparam int MAW       = $clog2(MEM_WORDS);
  localparam int MCW       = $clog2(MEM_WORDS + 1);
  localparam int CW        = $clog2(DEPTH + 1);
  localparam int OCW       = $clog2(OUT_SLOTS + 1);

  generate
    if ((DEPTH % 2) != 0 || DEPTH < 4 || OUT_SLOTS < 4) begin : g_bad_cfg
      $error("DEPTH must be even and >= 4, OUT_SLOTS >= 4");
    end
  endgenerate

  logic [CW-1:0]     occ_q;
  logic [MCW-1:0]    mem_cnt_q;
  logic [MAW-1:0]    wptr_q, rptr_q;
  logic              rd_pend_q;
  logic              prio_wr_q;

  logic              wr_acc, pop;
  logic              single_vld, pair_vld;
  logic [DATA_W-1:0] single_data;
  logic [PAIR_W-1:0] pair_data, mem_rdata, ob_din;
  logic [OCW-1:0]    ocnt;
  logic              direct_ok, byp_pair, byp_single;
  logic              want_wr, want_rd, conflict, take_pair;
  grant_e            gnt;
  logic              mem_en, mem_we;
  logic [MAW-1:0]    mem_addr;

  function automatic logic [MAW-1:0] ptr_inc(input logic [MAW-1:0] p);
    return (p == MAW'(MEM_WORDS - 1)) ? '0 : p + 1'b1;
  endfunction

  // source selection and port arbitration
  always_comb begin
    direct_ok  = (mem_cnt_q == '0) && !rd_pend_q;
    byp_pair   = direct_ok && pair_vld && (int'(ocnt) <= OUT_SLOTS - 2);
    byp_single = direct_ok && !pair_vld && single_vld && (int'(ocnt) <= OUT_SLOTS - 1);
    want_wr    = pair_vld && !byp_pair;
    want_rd    = (mem_cnt_q != '0) &&
                 (int'(ocnt) + (rd_pend_q ? 2 : 0) <= OUT_SLOTS - 2);
    conflict   = want_wr && want_rd;
    if (conflict)     gnt = prio_wr_q ? GNT_WR : GNT_RD;
    else if (want_wr) gnt = GNT_WR;
    else if (want_rd) gnt = GNT_RD;
    else              gnt = GNT_NONE;
  end

  assign take_pair = (gnt == GNT_WR) || byp_pair;
  assign mem_en    = (gnt != GNT_NONE);
  assign mem_we    = (gnt == GNT_WR);
  assign mem_addr  = mem_we ? wptr_q : rptr_q;

  assign wr_full_o  = (occ_q == CW'(DEPTH)) || (single_vld && pair_vld && !take_pair);
  assign empty_o    = (occ_q == '0);
  assign rd_valid_o = (ocnt != '0);
  assign wr_acc     = wr_valid_i && !wr_full_o;
  assign pop        = rd_valid_o && rd_ready_i;

  always_comb begin
    if (rd_pend_q)     ob_din = mem_rdata;
    else if (byp_pair) ob_din = pair_data;
    else               ob_din = {{DATA_W{1'b0}}, single_data};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      occ_q     <= '0;
      mem_cnt_q <= '0;
      wptr_q    <= '0;
      rptr_q    <= '0;
      rd_pend_q <= 1'b0;
      prio_wr_q <= 1'b0;
    end else begin
      if (wr_acc && !pop)      occ_q <= occ_q + 1'b1;
      else if (!wr_acc && pop) occ_q <= occ_q - 1'b1;

      if (gnt == GNT_WR) begin
        mem_cnt_q <= mem_cnt_q + 1'b1;
        wptr_q    <= ptr_inc(wptr_q);
      end else if (gnt == GNT_RD) begin
        mem_cnt_q <= mem_cnt_q - 1'b1;
        rptr_q    <= ptr_inc(rptr_q);
      end

      rd_pend_q <= (gnt == GNT_RD);
      if (conflict) prio_wr_q <= !prio_wr_q;
    end
  end

  pp_in_stage #(.DW(DATA_W)) i_in_stage (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_acc),
    .wdata_i       (wr_data_i),
    .take_single_i (byp_single),
    .take_pair_i   (take_pair),
    .single_vld_o  (single_vld),
    .single_o      (single_data),
    .pair_vld_o    (pair_vld),
    .pair_o        (pair_data)
  );

  pp_sp_ram #(.DW(PAIR_W), .WORDS(MEM_WORDS)) i_ram (
    .clk_i   (clk_i),
    .en_i    (mem_en),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (pair_data),
    .rdata_o (mem_rdata)
  );

  pp_out_stage #(.DW(DATA_W), .SLOTS(OUT_SLOTS)) i_out_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push1_i (byp_single),
    .push2_i (rd_pend_q || byp_pair),
    .din_i   (ob_din),
    .pop_i   (pop),
    .cnt_o   (ocnt),
    .head_o  (rd_data_o)
  );
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              wr_full_i,
  input logic              rd_ready_i,
  input logic              rd_valid_i,
  input logic [DATA_W-1:0] rd_data_i,
  input logic              empty_i,
  input logic              pair_vld_i,
  input logic              pair_leave_i
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] occ_q;
  logic          acc, pop;

  assign acc = wr_valid_i && !wr_full_i;
  assign pop = rd_valid_i && rd_ready_i;

  // occupancy seen purely from port handshakes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          occ_q <= '0;
    else if (acc && !pop) occ_q <= occ_q + 1'b1;
    else if (!acc && pop) occ_q <= occ_q - 1'b1;
  end

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == CW'(DEPTH)) |-> wr_full_i);

  assert_full_only_at_depth_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_full_i |-> (occ_q == CW'(DEPTH)));

  assert_empty_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i == (occ_q == '0));

  assert_valid_not_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |-> !empty_i);

  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && !rd_ready_i) |=> (rd_valid_i && $stable(rd_data_i)));

  assert_lone_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_i && wr_valid_i && !wr_full_i) |=> ##1 rd_valid_i);

  assert_pair_drain_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pair_vld_i && !pair_leave_i) |=> pair_leave_i);
endmodule

bind pairpack_fifo pp_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_pp_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .wr_full_i    (wr_full_o),
  .rd_ready_i   (rd_ready_i),
  .rd_valid_i   (rd_valid_o),
  .rd_data_i    (rd_data_o),
  .empty_i      (empty_o),
  .pair_vld_i   (pair_vld),
  .pair_leave_i (take_pair)
);

// File: tb/test_pairpack_fifo.sv
module test_pairpack_fifo;
  localparam int DW    = 32;
  localparam int DEPTH = 32;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          wr_valid_i, rd_ready_i;
  logic [DW-1:0] wr_data_i;
  logic          wr_full_o, rd_valid_o, empty_o;
  logic [DW-1:0] rd_data_o;

  logic [DW-1:0] q[$];
  int checks = 0;
  int errors = 0;
  int popped = 0;

  always #4 clk = ~clk;

  pairpack_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_pairpack_fifo (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .wr_data_i  (wr_data_i),
    .wr_full_o  (wr_full_o),
    .rd_ready_i (rd_ready_i),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .empty_o    (empty_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one clock: compare at negedge, update model, drive for next edge
  task automatic cyc(input logic w, input logic [DW-1:0] d, input logic r);
    @(negedge clk);
    chk(wr_full_o == (q.size() == DEPTH), "R8", "full vs occupancy",
        32'(wr_full_o), 32'(q.size() == DEPTH));
    chk(empty_o == (q.size() == 0), "R6", "empty vs occupancy",
        32'(empty_o), 32'(q.size() == 0));
    if (r && rd_valid_o) begin
      if (q.size() == 0) chk(1'b0, "R1", "word with model empty", rd_data_o, 32'h0);
      else begin
        chk(rd_data_o == q[0], "R1", "read data", rd_data_o, q[0]);
        void'(q.pop_front());
        popped++;
      end
    end
    if (w && !wr_full_o) q.push_back(d);
    wr_valid_i = w;
    wr_data_i  = d;
    rd_ready_i = r;
  endtask

  task automatic drain();
    int guard = 0;
    while (q.size() > 0 && guard < 400) begin
      cyc(1'b0, '0, 1'b1);
      guard++;
    end
    cyc(1'b0, '0, 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk(empty_o == 1'b1, "R6", "empty after drain", 32'(empty_o), 32'd1);
    chk(rd_valid_o == 1'b0, "R6", "no valid after drain", 32'(rd_valid_o), 32'd0);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    rst_ni     = 1'b0;
    wr_valid_i = 1'b0;
    rd_ready_i = 1'b0;
    wr_data_i  = '0;
    repeat (3) @(negedge clk);
    chk(rd_valid_o == 1'b0, "R2", "valid in reset", 32'(rd_valid_o), 32'd0);
    chk(empty_o == 1'b1, "R2", "empty in reset", 32'(empty_o), 32'd1);
    chk(wr_full_o == 1'b0, "R2", "full in reset", 32'(wr_full_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(rd_valid_o == 1'b0 && empty_o && !wr_full_o, "R2", "state after reset",
        {29'd0, rd_valid_o, empty_o, wr_full_o}, 32'd2);

    // R5 lone word, R9 hold
    cyc(1'b1, 32'hA5A5_0001, 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk(rd_valid_o == 1'b0, "R5", "valid one edge after write", 32'(rd_valid_o), 32'd0);
    cyc(1'b0, '0, 1'b0);
    chk(rd_valid_o == 1'b1, "R5", "valid two edges after write", 32'(rd_valid_o), 32'd1);
    chk(rd_data_o == 32'hA5A5_0001, "R5", "lone word data", rd_data_o, 32'hA5A5_0001);
    cyc(1'b0, '0, 1'b0);
    chk(rd_valid_o == 1'b1, "R9", "valid held", 32'(rd_valid_o), 32'd1);
    chk(rd_data_o == 32'hA5A5_0001, "R9", "data held", rd_data_o, 32'hA5A5_0001);
    drain();

    // R10 odd burst
    popped = 0;
    for (int i = 0; i < 5; i++) cyc(1'b1, 32'h1000 + 32'(i), 1'b0);
    repeat (4) cyc(1'b0, '0, 1'b0);
    chk(rd_valid_o == 1'b1, "R10", "odd burst visible", 32'(rd_valid_o), 32'd1);
    drain();
    chk(popped == 5, "R10", "odd burst count", 32'(popped), 32'd5);

    // R3 fill past capacity
    popped = 0;
    for (int i = 0; i < DEPTH + 3; i++) cyc(1'b1, 32'h2000 + 32'(i), 1'b0);
    cyc(1'b0, '0, 1'b0);
    chk(wr_full_o == 1'b1, "R3", "full at depth", 32'(wr_full_o), 32'd1);
    drain();
    chk(popped == DEPTH, "R3", "words after overfill", 32'(popped), 32'(DEPTH));

    // R7 / R4 sustained streaming
    for (int i = 0; i < 12; i++) cyc(1'b1, 32'h3000 + 32'(i), 1'b0);
    repeat (3) cyc(1'b0, '0, 1'b0);
    for (int i = 0; i < 400; i++) begin
      cyc(1'b1, 32'h4000 + 32'(i), 1'b1);
      chk(rd_valid_o == 1'b1, "R7", "valid during stream", 32'(rd_valid_o), 32'd1);
      chk(wr_full_o == 1'b0, "R4", "write not refused in stream", 32'(wr_full_o), 32'd0);
    end
    drain();

    // R1 random traffic with varied densities
    begin
      int wp[8] = '{50, 90, 30, 100, 70, 100, 20, 60};
      int rp[8] = '{50, 30, 90, 100, 70, 60, 20, 100};
      for (int s = 0; s < 8; s++) begin
        for (int i = 0; i < 500; i++) begin
          cyc(($urandom_range(99) < wp[s]), $urandom(), ($urandom_range(99) < rp[s]));
        end
      end
    end
    drain();

    summary();
    $finish;
  end
endmodule